// File: doc/BRIEF.md
# Avalon-MM Slave Command Queue

This block is an Avalon-MM slave front end that decouples the master from a slow backend. Read and write commands are posted into an internal queue, so the master can move on without holding its signals. The slave stalls the master only when the queue has no room left. Queued commands drain in order, at most one per cycle, into a small on-block word memory.

Writes update the memory when they retire. A read keeps the memory port busy for a configurable number of cycles (1 to 3). Its data then comes back in a separate data phase, flagged by `readdatavalid`. The observed read latency therefore varies with queue occupancy and is decided entirely by the slave.

The queue depth is a parameter of at least one. A depth of one turns the queue into a single holding register.

Top module: `aq_slave_cmdq`

## Requirements
- R1: Once reset is released, `waitrequest` and `readdatavalid` are low, and a read of any word that has not yet been written returns zero.
- R2: When the queue has room, a cycle with `read` or `write` high accepts the command in that same cycle, and `waitrequest` stays low.
- R3: `waitrequest` is high only in a cycle where the queue holds DEPTH commands and the backend retires none. A command held through such cycles is accepted exactly once, in the first cycle where `waitrequest` is low.
- R4: When the queue is full and the backend retires an entry in the same cycle, a presented command is accepted in that cycle, with `waitrequest` low.
- R5: Commands retire in the order they were accepted, at most one per clock. A write changes the addressed word when it retires.
- R6: Suppose a read retires at clock edge E. Then `readdatavalid` is high, with `readdata`, for the one cycle that follows edge E+RD_LAT, with RD_LAT between 1 and 3. No other command retires before edge E+RD_LAT.
- R7: A read accepted after a write to the same address returns the newly written value, even when both sit in the queue together.
- R8: The block behaves identically with DEPTH=1, where the queue is a single holding register. It also behaves identically with a DEPTH that is not a power of two, where the ring pointers wrap at DEPTH-1.
- R9: A cycle with `read` and `write` both low queues nothing, and produces no `readdatavalid` beyond those owed to reads accepted earlier. Read results come back in the order the reads were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| address | input | AW | Word address of the command |
| writedata | input | DW | Data for a write command |
| read | input | 1 | Read command request |
| write | input | 1 | Write command request (the master never raises it together with read) |
| waitrequest | output | 1 | Command not taken this cycle; master holds its signals |
| readdata | output | DW | Returned read data, meaningful while readdatavalid is high |
| readdatavalid | output | 1 | One-cycle marker for each returned read |

## Verification
The bench builds two instances that share one behavioural reference model type.

The first uses DEPTH=3 and RD_LAT=3. This exercises ring pointer wrap at a depth that is not a power of two, together with the longest read occupancy, so bursts of reads fill the queue and produce both stalls and full-and-retire acceptances.

The second uses DEPTH=1 and RD_LAT=2. This reduces the queue to a holding register that changes hands in the same cycle it drains.

A write followed by a read of the same address is placed behind pending reads, so that both sit in the queue at once. A long random mix over a small address range then repeats such read-after-write cases many times.

// File: rtl/aq_pkg.sv
package aq_pkg;
  typedef enum logic {
    BE_IDLE = 1'b0,
    BE_READ = 1'b1
  } be_state_e;
endpackage

// File: rtl/aq_rst_sync.sv
module aq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/aq_fifo.sv
module aq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic         full,
  output logic         empty,
  output logic [W-1:0] dout
);
  generate
    if (DEPTH == 1) begin : g_hold
      logic         v_q, v_d;
      logic [W-1:0] r_q;
      always_comb v_d = (v_q & ~pop) | push;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= 1'b0;
        else        v_q <= v_d;
      end
      always_ff @(posedge clk) begin
        if (push) r_q <= din;
      end
      assign full  = v_q;
      assign empty = ~v_q;
      assign dout  = r_q;
    end else begin : g_ring
      localparam int PW = $clog2(DEPTH);
      localparam int CW = $clog2(DEPTH + 1);
      logic [W-1:0]  slot_q [DEPTH];
      logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
      logic [CW-1:0] cnt_q, cnt_d;

      function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
      endfunction

      always_comb begin
        wp_d  = push ? step(wp_q) : wp_q;
        rp_d  = pop  ? step(rp_q) : rp_q;
        cnt_d = cnt_q;
        if (push && !pop)      cnt_d = cnt_q + 1'b1;
        else if (pop && !push) cnt_d = cnt_q - 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wp_q  <= '0;
          rp_q  <= '0;
          cnt_q <= '0;
        end else begin
          wp_q  <= wp_d;
          rp_q  <= rp_d;
          cnt_q <= cnt_d;
        end
      end

      always_ff @(posedge clk) begin
        if (push) slot_q[wp_q] <= din;
      end

      assign full  = (cnt_q == CW'(DEPTH));
      assign empty = (cnt_q == '0);
      assign dout  = slot_q[rp_q];
    end
  endgenerate
endmodule

// File: rtl/aq_backend.sv
module aq_backend
  import aq_pkg::*;
#(
  parameter int AW     = 4,
  parameter int DW     = 16,
  parameter int RD_LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          is_wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic          busy,
  output logic          rdv,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;
  localparam int CW    = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;

  be_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] ra_q, ra_d;
  logic          rdv_d;
  logic [DW-1:0] rdata_d;
  logic [DW-1:0] mem [WORDS];

  assign ready = (st_q == BE_IDLE) || (cnt_q == '0);
  assign busy  = (st_q == BE_READ);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    ra_d    = ra_q;
    rdv_d   = 1'b0;
    rdata_d = rdata;
    if (st_q == BE_READ) begin
      if (cnt_q == '0) begin
        rdv_d   = 1'b1;
        rdata_d = mem[ra_q];
        st_d    = BE_IDLE;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    if (issue && !is_wr) begin
      st_d  = BE_READ;
      cnt_d = CW'(RD_LAT - 1);
      ra_d  = addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BE_IDLE;
      cnt_q <= '0;
      ra_q  <= '0;
      rdv   <= 1'b0;
      rdata <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      ra_q  <= ra_d;
      rdv   <= rdv_d;
      rdata <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (issue && is_wr) begin
      mem[addr] <= wdata;
    end
  end
endmodule

// File: rtl/aq_slave_cmdq.sv
module aq_slave_cmdq #(
  parameter int AW     = 4,
  parameter int DW     = 16,
  parameter int DEPTH  = 4,
  parameter int RD_LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] address,
  input  logic [DW-1:0] writedata,
  input  logic          read,
  input  logic          write,
  output logic          waitrequest,
  output logic [DW-1:0] readdata,
  output logic          readdatavalid
);
  localparam int CMDW = 1 + AW + DW;

  logic            srst_n;
  logic            q_full, q_empty, pop, push, be_ready, be_busy;
  logic [CMDW-1:0] head;
  logic            h_wr;
  logic [AW-1:0]   h_addr;
  logic [DW-1:0]   h_data;

  aq_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  assign pop         = !q_empty && be_ready;
  assign waitrequest = q_full && !pop;
  assign push        = (read || write) && !waitrequest;

  aq_fifo #(.W(CMDW), .DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(srst_n), .push(push), .pop(pop),
    .din({write, address, writedata}),
    .full(q_full), .empty(q_empty), .dout(head)
  );

  assign {h_wr, h_addr, h_data} = head;

  aq_backend #(.AW(AW), .DW(DW), .RD_LAT(RD_LAT)) u_be (
    .clk(clk), .rst_n(srst_n), .issue(pop), .is_wr(h_wr),
    .addr(h_addr), .wdata(h_data), .ready(be_ready), .busy(be_busy),
    .rdv(readdatavalid), .rdata(readdata)
  );
endmodule

// File: rtl/aq_cmdq_chk.sv
module aq_cmdq_chk (
  input logic clk,
  input logic rst_n,
  input logic read,
  input logic write,
  input logic waitrequest,
  input logic readdatavalid,
  input logic q_full,
  input logic q_empty,
  input logic pop,
  input logic be_busy
);
  // R3: a stall is only raised against a full queue
  a_r3_wait_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    waitrequest |-> q_full);

  // R2: a request meets no stall while there is room
  a_r2_room_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    ((read || write) && !q_full) |-> !waitrequest);

  // R4: full queue that drains this cycle still takes the request
  a_r4_full_retire_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && pop) |-> !waitrequest);

  // R3: a stalled cycle neither pushes nor pops, so the queue stays full
  a_r3_stall_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    waitrequest |=> q_full);

  // R6: returned data is always preceded by a busy read port
  a_r6_data_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    readdatavalid |-> $past(be_busy));

  // R5: the backend only takes commands that exist
  a_r5_issue_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !q_empty);
endmodule

bind aq_slave_cmdq aq_cmdq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .read(read), .write(write),
  .waitrequest(waitrequest), .readdatavalid(readdatavalid),
  .q_full(q_full), .q_empty(q_empty), .pop(pop), .be_busy(be_busy)
);

// File: tb/tb_aq_slave_cmdq.sv
module tb_aq_ref #(
  parameter int AW = 4, parameter int DW = 16,
  parameter int DEPTH = 2, parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          exp_wreq,
  output logic          exp_rdv,
  output logic [DW-1:0] exp_rdata,
  output int            stalls,
  output int            fullpops
);
  typedef struct { bit w; int a; logic [DW-1:0] d; } cmd_t;
  cmd_t q[$];
  cmd_t c;
  int rem, raddr;
  bit pop, wq, full0;
  logic [DW-1:0] mem [1 << AW];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); rem = 0; raddr = 0;
      foreach (mem[i]) mem[i] = '0;
      exp_wreq = 0; exp_rdv = 0; exp_rdata = '0; stalls = 0; fullpops = 0;
    end else begin
      full0 = (q.size() == DEPTH);
      pop   = (q.size() > 0) && (rem <= 1);
      wq    = full0 && !pop;
      exp_rdv = 0;
      if (rem > 0) begin
        rem--;
        if (rem == 0) begin exp_rdv = 1; exp_rdata = mem[raddr]; end
      end
      if (pop) begin
        c = q.pop_front();
        if (c.w) mem[c.a] = c.d;
        else begin rem = LAT; raddr = c.a; end
      end
      if ((rd || wr) && wq) stalls++;
      if ((rd || wr) && !wq) begin
        if (full0) fullpops++;
        c.w = wr; c.a = int'(addr); c.d = wdata;
        q.push_back(c);
      end
      exp_wreq = (q.size() == DEPTH) && !((q.size() > 0) && (rem <= 1));
    end
  end
endmodule

module tb_aq_slave_cmdq;
  localparam int AW = 4, DW = 16;

  logic clk, rst_n;
  logic          rd [2], wr [2], wreq [2], rdv [2];
  logic [AW-1:0] ad [2];
  logic [DW-1:0] wd [2], rdat [2];
  logic          e_wreq [2], e_rdv [2];
  logic [DW-1:0] e_rdat [2];
  int            stl [2], fpo [2];
  int            n_chk = 0, n_fail = 0;
  bit            armed = 0;

  initial clk = 0;
  always #5 clk = ~clk;

  aq_slave_cmdq #(.AW(AW), .DW(DW), .DEPTH(3), .RD_LAT(3)) dut (
    .clk(clk), .rst_n(rst_n), .address(ad[0]), .writedata(wd[0]),
    .read(rd[0]), .write(wr[0]), .waitrequest(wreq[0]),
    .readdata(rdat[0]), .readdatavalid(rdv[0]));
  tb_aq_ref #(.AW(AW), .DW(DW), .DEPTH(3), .LAT(3)) ref0 (
    .clk(clk), .rst_n(rst_n), .rd(rd[0]), .wr(wr[0]), .addr(ad[0]),
    .wdata(wd[0]), .exp_wreq(e_wreq[0]), .exp_rdv(e_rdv[0]),
    .exp_rdata(e_rdat[0]), .stalls(stl[0]), .fullpops(fpo[0]));

  aq_slave_cmdq #(.AW(AW), .DW(DW), .DEPTH(1), .RD_LAT(2)) dut1 (
    .clk(clk), .rst_n(rst_n), .address(ad[1]), .writedata(wd[1]),
    .read(rd[1]), .write(wr[1]), .waitrequest(wreq[1]),
    .readdata(rdat[1]), .readdatavalid(rdv[1]));
  tb_aq_ref #(.AW(AW), .DW(DW), .DEPTH(1), .LAT(2)) ref1 (
    .clk(clk), .rst_n(rst_n), .rd(rd[1]), .wr(wr[1]), .addr(ad[1]),
    .wdata(wd[1]), .exp_wreq(e_wreq[1]), .exp_rdv(e_rdv[1]),
    .exp_rdata(e_rdat[1]), .stalls(stl[1]), .fullpops(fpo[1]));

  task automatic check(input string req, input int k, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s dut%0d t=%0t actual=%h expected=%h", req, k, $time, act, exp);
    end
  endtask

  // Per-cycle comparison against the behavioural model, away from the edge
  always @(negedge clk) begin
    if (armed) begin
      for (int k = 0; k < 2; k++) begin
        check("R2 R3 R4 R8 waitrequest", k, DW'(wreq[k]), DW'(e_wreq[k]));
        check("R6 R9 readdatavalid", k, DW'(rdv[k]), DW'(e_rdv[k]));
        if (e_rdv[k]) check("R5 R7 readdata", k, rdat[k], e_rdat[k]);
      end
    end
  end

  task automatic issue(input int k, input bit w, input int a, input logic [DW-1:0] d);
    rd[k] = !w; wr[k] = w; ad[k] = AW'(a); wd[k] = d;
    @(negedge clk);
    while (wreq[k]) @(negedge clk);
    @(posedge clk); #1;
    rd[k] = 0; wr[k] = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic scenario(input int k);
    issue(k, 0, 5, '0);                      // R1: unwritten word reads zero
    for (int i = 0; i < 8; i++) issue(k, 1, i, DW'(16'h1000 + i));
    for (int i = 0; i < 6; i++) issue(k, 0, i, '0);   // R3 R4: read burst fills queue
    issue(k, 0, 1, '0);
    issue(k, 1, 3, 16'hBEEF);                // R7: write then read while queued
    issue(k, 0, 3, '0);
    idle(6);                                 // R9: quiet cycles
    issue(k, 1, 7, 16'h7777);
    issue(k, 0, 7, '0);
    issue(k, 1, 7, 16'h8888);
    issue(k, 0, 7, '0);
    idle(8);
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom % 8);
      if (r == 0) idle(int'($urandom % 3) + 1);
      else issue(k, r > 4, int'($urandom % 6), DW'($urandom));
    end
    idle(12);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired t=%0t actual=running expected=done", $time);
    finish_run();
  end

  initial begin
    for (int k = 0; k < 2; k++) begin rd[k] = 0; wr[k] = 0; ad[k] = '0; wd[k] = '0; end
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle(4);
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      check("R1 reset waitrequest", k, DW'(wreq[k]), '0);
      check("R1 reset readdatavalid", k, DW'(rdv[k]), '0);
    end
    armed = 1;
    @(posedge clk); #1;
    scenario(0);
    scenario(1);
    for (int k = 0; k < 2; k++) begin
      check("R3 stall reached", k, DW'(stl[k] > 0), DW'(1));
      check("R4 full-and-retire acceptance reached", k, DW'(fpo[k] > 0), DW'(1));
    end
    finish_run();
  end
endmodule